// File: doc/BRIEF.md
# Receive I/Q DC Offset Removal Unit

This unit sits between the decimated 15-bit I and Q sample stream and the serial output framer. It holds one 10-bit two's-complement correction value per channel. It scales each value by four to line it up with the 15-bit sample word and subtracts it from every sample that passes through. The result saturates at the 15-bit limits.

Two correction modes exist, selected by `user_mode_i`. In automatic mode, every wake-up runs a self-measurement. The unit asks the analog front end to short its inputs and waits a fixed number of cycles. It then sums sixteen raw samples per channel, divides the sum by sixteen and then by the alignment factor, saturates the result to 10 bits and writes it into both correction registers. In user mode the unit never measures. The registers change only through the small write port, and they keep their contents while the receive path sleeps.

After each wake-up the sequencer holds the output stream quiet until a settling interval has elapsed. This interval is longer in automatic mode than in user mode, so that the first valid output word never carries filter or analog settling transients.

Top module: `rx_dc_cal`

## Requirements
- R1: After reset both correction registers are zero, `out_valid_o` and `short_req_o` are low and both output words are zero; a user-mode wake-up without writes then passes samples through unchanged.
- R2: `user_mode_i`=0 (automatic) starts a measurement on every wake-up and overwrites both registers each time; with `user_mode_i`=1 sampled at wake-up, `short_req_o` stays low for the whole awake period.
- R3: In automatic mode `short_req_o` rises after the wake edge and stays high until sixteen `in_valid_i` samples have been accumulated, starting CAL_START cycles after wake. The stored value is floor(floor(sum/16)/4), saturated to [-512, 511].
- R4: A write (`cfg_wr_i`=1, `cfg_sel_i` 0 = I register, 1 = Q register, value `cfg_data_i`) takes effect only while `user_mode_i`=1. In automatic mode the write is ignored.
- R5: Register contents survive any number of sleep/wake cycles in user mode.
- R6: Each output word equals the input word minus four times the sign-extended 10-bit register of its channel.
- R7: The subtraction clamps to 16383 and -16384 instead of wrapping.
- R8: Counting the rising edge that first samples `awake_i` high as edge 0, with `in_valid_i` held high, `out_valid_o` first goes high after edge L+1. L is AUTO_SETTLE in automatic mode and USER_SETTLE in user mode.
- R9: `out_valid_o` is low while `short_req_o` is high. One cycle after `awake_i` is sampled low, both `out_valid_o` and `short_req_o` are low. An interrupted measurement writes nothing.
- R10: In the running state each accepted input produces an output one cycle later, and `out_valid_o` is high only for a cycle that follows a high `in_valid_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awake_i | input | 1 | 1 = receive path active, 0 = sleep |
| user_mode_i | input | 1 | 0 = automatic measurement, 1 = user-loaded offsets |
| cfg_wr_i | input | 1 | Write strobe for a correction register |
| cfg_sel_i | input | 1 | Register select: 0 = I, 1 = Q |
| cfg_data_i | input | 10 | Two's-complement value to write |
| in_valid_i | input | 1 | Input sample pair valid |
| in_i | input | 15 | I sample, two's complement |
| in_q | input | 15 | Q sample, two's complement |
| short_req_o | output | 1 | Request to short the analog inputs |
| out_valid_o | output | 1 | Corrected sample pair valid |
| out_i | output | 15 | Corrected I sample |
| out_q | output | 15 | Corrected Q sample |

## Verification
On every cycle, the checker confirms four things: no output word escapes while the inputs are shorted, sleep silences both outputs one cycle later, a user-mode wake never requests shorting, and no valid word appears before the settling interval of the mode latched at wake. It also checks that each valid output follows a valid input. The arithmetic can only be shown by the bench scenarios: the averaging with its floor rounding and its register saturation, the aligned subtraction and its clamps, the write gating by mode, and retention across sleep. Each of these needs known register contents and chosen sample values.

// File: rtl/rx_dc_cal_pkg.sv
package rx_dc_cal_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_SETTLE_USER,
        ST_PRE_MEAS,
        ST_MEASURE,
        ST_COMMIT,
        ST_DRAIN,
        ST_RUN
    } seq_state_t;

endpackage

// File: rtl/rx_dc_seq.sv
module rx_dc_seq
    import rx_dc_cal_pkg::*;
#(
    parameter int CAL_START   = 2048,
    parameter int AUTO_SETTLE = 10240,
    parameter int USER_SETTLE = 6144,
    parameter int AVG_LOG2    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic awake_i,
    input  logic user_mode_i,
    input  logic in_valid_i,
    output logic short_req_o,
    output logic acc_clr_o,
    output logic acc_en_o,
    output logic commit_o,
    output logic take_o,
    output logic out_valid_o
);

    localparam int LIM_MAX = (AUTO_SETTLE > USER_SETTLE) ? AUTO_SETTLE : USER_SETTLE;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_TOP    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(CAL_START - 1);
    localparam logic [CNT_W-1:0] AUTO_LAST  = CNT_W'(AUTO_SETTLE - 1);
    localparam logic [CNT_W-1:0] USER_LAST  = CNT_W'(USER_SETTLE - 1);

    seq_state_t         state_q, state_d;
    logic [CNT_W-1:0]   wake_cnt_q;
    logic [AVG_LOG2-1:0] meas_cnt_q;
    logic               meas_last;
    logic               running;

    assign meas_last = (state_q == ST_MEASURE) && in_valid_i && (&meas_cnt_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!awake_i) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_SLEEP:       state_d = user_mode_i ? ST_SETTLE_USER : ST_PRE_MEAS;
                ST_SETTLE_USER: if (wake_cnt_q >= USER_LAST)  state_d = ST_RUN;
                ST_PRE_MEAS:    if (wake_cnt_q >= START_LAST) state_d = ST_MEASURE;
                ST_MEASURE:     if (meas_last)                state_d = ST_COMMIT;
                ST_COMMIT:      state_d = ST_DRAIN;
                ST_DRAIN:       if (wake_cnt_q >= AUTO_LAST)  state_d = ST_RUN;
                ST_RUN:         state_d = ST_RUN;
                default:        state_d = ST_SLEEP;
            endcase
        end
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_SLEEP;
            wake_cnt_q <= '0;
            meas_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SLEEP)
                wake_cnt_q <= '0;
            else if (wake_cnt_q != CNT_TOP)
                wake_cnt_q <= wake_cnt_q + 1'b1;
            if (state_q != ST_MEASURE)
                meas_cnt_q <= '0;
            else if (in_valid_i)
                meas_cnt_q <= meas_cnt_q + 1'b1;
        end
    end

    // Moore outputs
    always_comb begin
        short_req_o = 1'b0;
        acc_clr_o   = 1'b0;
        acc_en_o    = 1'b0;
        commit_o    = 1'b0;
        running     = 1'b0;
        unique case (state_q)
            ST_SLEEP:       acc_clr_o = 1'b1;
            ST_SETTLE_USER: acc_clr_o = 1'b1;
            ST_PRE_MEAS: begin
                short_req_o = 1'b1;
                acc_clr_o   = 1'b1;
            end
            ST_MEASURE: begin
                short_req_o = 1'b1;
                acc_en_o    = in_valid_i;
            end
            ST_COMMIT:      commit_o = 1'b1;
            ST_DRAIN:       acc_clr_o = 1'b1;
            ST_RUN:         running = 1'b1;
            default:        acc_clr_o = 1'b1;
        endcase
    end

    assign take_o = running && awake_i && in_valid_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid_o <= 1'b0;
        else        out_valid_o <= take_o;
    end

endmodule

// File: rtl/rx_dc_avg.sv
module rx_dc_avg #(
    parameter int SAMPLE_W = 15,
    parameter int OFF_W    = 10,
    parameter int AVG_LOG2 = 4,
    parameter int ALIGN_SH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                en_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [OFF_W-1:0]    off_o
);

    localparam int ACC_W = SAMPLE_W + AVG_LOG2;
    localparam int SHIFT = AVG_LOG2 + ALIGN_SH;
    localparam int HI_W  = ACC_W - OFF_W + 1;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] scaled;
    logic [HI_W-1:0]         hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_q <= '0;
        else if (clr_i) acc_q <= '0;
        else if (en_i)  acc_q <= acc_q + ACC_W'($signed(sample_i));
    end

    assign scaled = acc_q >>> SHIFT;
    assign hi     = scaled[ACC_W-1:OFF_W-1];

    always_comb begin
        if ((&hi) || !(|hi))
            off_o = scaled[OFF_W-1:0];
        else if (scaled[ACC_W-1])
            off_o = {1'b1, {(OFF_W-1){1'b0}}};
        else
            off_o = {1'b0, {(OFF_W-1){1'b1}}};
    end

endmodule

// File: rtl/rx_dc_offset_regs.sv
module rx_dc_offset_regs
    import rx_dc_cal_pkg::*;
#(
    parameter int OFF_W = 10,
    parameter int SEL_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          user_mode_i,
    input  logic                          wr_en_i,
    input  logic [SEL_W-1:0]              wr_sel_i,
    input  logic [OFF_W-1:0]              wr_data_i,
    input  logic                          load_i,
    input  logic [NUM_CH-1:0][OFF_W-1:0]  cal_i,
    output logic [NUM_CH-1:0][OFF_W-1:0]  off_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                off_o[c] <= '0;
            else if (load_i)
                off_o[c] <= cal_i[c];
            else if (user_mode_i && wr_en_i && (wr_sel_i == SEL_W'(c)))
                off_o[c] <= wr_data_i;
        end
    end

endmodule

// File: rtl/rx_dc_sub.sv
module rx_dc_sub #(
    parameter int SAMPLE_W = 15,
    parameter int OFF_W    = 10,
    parameter int ALIGN_SH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [OFF_W-1:0]    off_i,
    output logic [SAMPLE_W-1:0] out_o
);

    localparam int EXT_W = SAMPLE_W + 1;
    localparam int PAD_W = EXT_W - OFF_W - ALIGN_SH;

    logic [EXT_W-1:0]    ext_s, ext_o, diff;
    logic [SAMPLE_W-1:0] clamped;

    assign ext_s = {sample_i[SAMPLE_W-1], sample_i};
    assign ext_o = {{PAD_W{off_i[OFF_W-1]}}, off_i, {ALIGN_SH{1'b0}}};
    assign diff  = ext_s - ext_o;

    always_comb begin
        if (diff[EXT_W-1] != diff[EXT_W-2])
            clamped = diff[EXT_W-1] ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                                    : {1'b0, {(SAMPLE_W-1){1'b1}}};
        else
            clamped = diff[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out_o <= '0;
        else if (take_i) out_o <= clamped;
    end

endmodule

// File: rtl/rx_dc_cal.sv
module rx_dc_cal
    import rx_dc_cal_pkg::*;
#(
    parameter int SAMPLE_W    = 15,
    parameter int OFF_W       = 10,
    parameter int ALIGN_SH    = 2,
    parameter int AVG_LOG2    = 4,
    parameter int CAL_START   = 2048,
    parameter int AUTO_SETTLE = 10240,
    parameter int USER_SETTLE = 6144
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                awake_i,
    input  logic                user_mode_i,
    input  logic                cfg_wr_i,
    input  logic                cfg_sel_i,
    input  logic [OFF_W-1:0]    cfg_data_i,
    input  logic                in_valid_i,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic                short_req_o,
    output logic                out_valid_o,
    output logic [SAMPLE_W-1:0] out_i,
    output logic [SAMPLE_W-1:0] out_q
);

    logic acc_clr, acc_en, commit, take;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] smp, res;
    logic [NUM_CH-1:0][OFF_W-1:0]    cal_off, cur_off;

    assign smp[0] = in_i;
    assign smp[1] = in_q;
    assign out_i  = res[0];
    assign out_q  = res[1];

    rx_dc_seq #(
        .CAL_START   (CAL_START),
        .AUTO_SETTLE (AUTO_SETTLE),
        .USER_SETTLE (USER_SETTLE),
        .AVG_LOG2    (AVG_LOG2)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .awake_i     (awake_i),
        .user_mode_i (user_mode_i),
        .in_valid_i  (in_valid_i),
        .short_req_o (short_req_o),
        .acc_clr_o   (acc_clr),
        .acc_en_o    (acc_en),
        .commit_o    (commit),
        .take_o      (take),
        .out_valid_o (out_valid_o)
    );

    rx_dc_offset_regs #(
        .OFF_W (OFF_W),
        .SEL_W (1)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .user_mode_i (user_mode_i),
        .wr_en_i     (cfg_wr_i),
        .wr_sel_i    (cfg_sel_i),
        .wr_data_i   (cfg_data_i),
        .load_i      (commit),
        .cal_i       (cal_off),
        .off_o       (cur_off)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rx_dc_avg #(
            .SAMPLE_W (SAMPLE_W),
            .OFF_W    (OFF_W),
            .AVG_LOG2 (AVG_LOG2),
            .ALIGN_SH (ALIGN_SH)
        ) avg_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (acc_clr),
            .en_i     (acc_en),
            .sample_i (smp[c]),
            .off_o    (cal_off[c])
        );

        rx_dc_sub #(
            .SAMPLE_W (SAMPLE_W),
            .OFF_W    (OFF_W),
            .ALIGN_SH (ALIGN_SH)
        ) sub_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_i   (take),
            .sample_i (smp[c]),
            .off_i    (cur_off[c]),
            .out_o    (res[c])
        );
    end

endmodule

// File: rtl/rx_dc_cal_chk.sv
module rx_dc_cal_chk #(
    parameter int AUTO_SETTLE = 10240,
    parameter int USER_SETTLE = 6144
) (
    input logic clk,
    input logic rst_n,
    input logic awake_i,
    input logic user_mode_i,
    input logic in_valid_i,
    input logic short_req_o,
    input logic out_valid_o
);

    logic        awake_q;
    logic        mode_q;
    logic [31:0] since_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            awake_q    <= 1'b0;
            mode_q     <= 1'b0;
            since_wake <= '0;
        end else begin
            awake_q <= awake_i;
            if (awake_i && !awake_q) begin
                mode_q     <= user_mode_i;
                since_wake <= '0;
            end else if (since_wake != 32'hFFFF_FFFF) begin
                since_wake <= since_wake + 1'b1;
            end
        end
    end

    a_r9_quiet_while_shorted: assert property (@(posedge clk) disable iff (!rst_n)
        short_req_o |-> !out_valid_o);

    a_r9_sleep_silences: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_i |=> (!out_valid_o && !short_req_o));

    a_r2_user_never_shorts: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_i && awake_q && mode_q) |-> !short_req_o);

    a_r8_settle_respected: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (since_wake > (mode_q ? 32'(USER_SETTLE) : 32'(AUTO_SETTLE))));

    a_r10_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i));

endmodule

bind rx_dc_cal rx_dc_cal_chk #(
    .AUTO_SETTLE (AUTO_SETTLE),
    .USER_SETTLE (USER_SETTLE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .awake_i     (awake_i),
    .user_mode_i (user_mode_i),
    .in_valid_i  (in_valid_i),
    .short_req_o (short_req_o),
    .out_valid_o (out_valid_o)
);

// File: tb/rx_dc_cal_tb_top.sv
`timescale 1ns/1ps
module rx_dc_cal_tb_top;

    localparam int CAL_START   = 8;
    localparam int AUTO_SETTLE = 64;
    localparam int USER_SETTLE = 40;

    // {in_i, in_q, expected out_i, expected out_q} with I reg = 511, Q reg = -512
    localparam int NVEC = 6;
    localparam int VEC [NVEC][4] = '{
        '{0,      0,      -2044,  2048},
        '{5000,   -5000,  2956,   -2952},
        '{-15000, 15000,  -16384, 16383},
        '{16383,  -16384, 14339,  -14336},
        '{-14340, 14335,  -16384, 16383},
        '{-14341, 14336,  -16384, 16383}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awake_i = 1'b0;
    logic        user_mode_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic        cfg_sel_i = 1'b0;
    logic [9:0]  cfg_data_i = '0;
    logic        in_valid_i = 1'b0;
    logic [14:0] in_i = '0;
    logic [14:0] in_q = '0;
    logic        short_req_o, out_valid_o;
    logic [14:0] out_i, out_q;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    int  first;
    bit  saw_short;

    always #2.5 clk = ~clk;

    rx_dc_cal #(
        .CAL_START   (CAL_START),
        .AUTO_SETTLE (AUTO_SETTLE),
        .USER_SETTLE (USER_SETTLE)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .awake_i     (awake_i),
        .user_mode_i (user_mode_i),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_data_i  (cfg_data_i),
        .in_valid_i  (in_valid_i),
        .in_i        (in_i),
        .in_q        (in_q),
        .short_req_o (short_req_o),
        .out_valid_o (out_valid_o),
        .out_i       (out_i),
        .out_q       (out_q)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // wake with given mode; I alternates between i0 and i0+istep, Q constant
    task automatic wake(bit user, int i0, int istep, int q0);
        int n = -1;
        user_mode_i = user;
        awake_i     = 1'b1;
        in_valid_i  = 1'b1;
        in_i        = 15'(i0);
        in_q        = 15'(q0);
        first       = -1;
        saw_short   = 1'b0;
        for (int k = 0; k < 4 * AUTO_SETTLE; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (short_req_o) saw_short = 1'b1;
            if (out_valid_o) begin
                first = n;
                break;
            end
            in_i = 15'((n % 2 == 0) ? i0 + istep : i0);
        end
    endtask

    task automatic sleep_now();
        awake_i    = 1'b0;
        in_valid_i = 1'b0;
        step();
    endtask

    task automatic feed(string req, int vi, int vq, int ei, int eq);
        in_valid_i = 1'b1;
        in_i = 15'(vi);
        in_q = 15'(vq);
        step();
        check({req, " valid"}, int'(out_valid_o), 1);
        check({req, " I"}, int'($signed(out_i)), ei);
        check({req, " Q"}, int'($signed(out_q)), eq);
    endtask

    task automatic write_reg(bit sel, int val);
        cfg_wr_i   = 1'b1;
        cfg_sel_i  = sel;
        cfg_data_i = 10'(val);
        step();
        cfg_wr_i   = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid after reset", int'(out_valid_o), 0);
        check("R1 short_req after reset", int'(short_req_o), 0);
        check("R1 out_i after reset", int'(out_i), 0);
        rst_n = 1'b1;
        step();

        // R1/R2/R8: user wake, no writes -> pass-through
        wake(1'b1, 1234, 0, -777);
        check("R8 user first valid edge", first, USER_SETTLE + 1);
        check("R2 no short in user mode", int'(saw_short), 0);
        feed("R1 zero offset", 1234, -777, 1234, -777);

        // R6/R7: table walk with extreme offsets
        write_reg(1'b0, 511);
        write_reg(1'b1, -512);
        for (int k = 0; k < NVEC; k++)
            feed("R6 R7 vector", VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3]);

        // R10: no input -> no output
        in_valid_i = 1'b0;
        step();
        check("R10 idle input gives no output", int'(out_valid_o), 0);

        // R4 accepted while asleep in user mode, R5 retention
        sleep_now();
        write_reg(1'b0, 50);
        write_reg(1'b1, -20);
        wake(1'b1, 0, 0, 0);
        check("R8 user wake again", first, USER_SETTLE + 1);
        feed("R4 user write", 1000, 1000, 800, 1080);
        sleep_now();
        wake(1'b1, 0, 0, 0);
        feed("R5 retained through sleep", 1000, 1000, 800, 1080);

        // R3/R8: automatic calibration with floor rounding
        sleep_now();
        wake(1'b0, 401, 2, -5);
        check("R8 auto first valid edge", first, AUTO_SETTLE + 1);
        check("R3 short requested", int'(saw_short), 1);
        check("R3 short released", int'(short_req_o), 0);
        feed("R3 averaged offset", 1000, 1000, 600, 1008);

        // R4: write ignored in automatic mode
        write_reg(1'b0, 0);
        feed("R4 write ignored in auto", 1000, 1000, 600, 1008);

        // R2/R3: recalibration overwrites, average saturates
        sleep_now();
        wake(1'b0, 5000, 0, -3000);
        feed("R3 saturated average", 0, 0, -2044, 2048);

        // R9: interrupted measurement
        sleep_now();
        user_mode_i = 1'b0;
        awake_i     = 1'b1;
        in_valid_i  = 1'b1;
        in_i = 15'(100);
        in_q = 15'(100);
        repeat (12) step();
        check("R9 shorting during measurement", int'(short_req_o), 1);
        awake_i = 1'b0;
        step();
        check("R9 short dropped on sleep", int'(short_req_o), 0);
        check("R9 valid low on sleep", int'(out_valid_o), 0);
        wake(1'b1, 0, 0, 0);
        feed("R9 aborted measurement wrote nothing", 0, 0, -2044, 2048);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule